// File: doc/BRIEF.md
# Seconds Counter with Prescaler and Alarm

This block is a real-time clock for a register-mapped peripheral space. A slow 32.768 kHz reference arrives as a single-cycle enable on the system clock. A prescaler counts those enables and produces one tick per second. Each tick advances a 32-bit seconds count. The count is compared against a programmable alarm value.

Two sticky event flags record each tick and each alarm match. Each flag has its own enable, and together they drive two independent interrupt lines. Software sets the time by writing the count. A trim field is stored next to the divider and reads back, but it does not change the tick rate.

The register bus uses a two-bit word index, a write strobe and a combinational read port. Register indices are: 0 count, 1 alarm, 2 status, 3 trim/divider.

Top module: `rtc_core`

## Requirements
- R1: After reset, all four registers read 0 and both interrupt outputs are low.
- R2: With divider field D (nonzero), a tick occurs on every D+1 cycles in which `en32k` is high. Cycles with `en32k` low do not advance the prescaler.
- R3: While the divider field (bits 15:0 of index 3) is zero, the prescaler uses 32767, so the first tick after reset needs 32768 enables.
- R4: Each tick adds one to the count (index 0). A write to index 0 loads the count, and a read returns the current count.
- R5: When a count write and a tick fall in the same cycle, the count takes the written value and the tick's increment is lost.
- R6: Status bit 1 (tick flag) is set on every tick. Status bit 0 (alarm flag) is set on a tick, with no count write in that cycle, whose increment makes the count equal the alarm register (index 1). Both flags are set whatever the enables hold.
- R7: Writing 1 to status bit 0 or 1 clears that flag, and writing 0 leaves it. If a set and a clear reach the same flag in one cycle, the set wins.
- R8: Status bit 2 is the alarm enable and bit 3 the tick enable, each two positions above its flag. A status write loads both enables from bits 3:2. Status bits 31:4 read 0.
- R9: `irq_alarm` is high exactly when the alarm flag and the alarm enable are both 1. `irq_tick` is high exactly when the tick flag and the tick enable are both 1.
- R10: Index 3 stores all 32 bits: the divider in bits 15:0 and the trim in bits 31:16. The trim has no effect on the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en32k | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_tick | output | 1 | Once-per-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The hardest situation to reach from the ports is a register write that lands in exactly the cycle of a tick. One case is a count write against the increment; the other is a flag clear against the flag set. The bench programs a short divider and keeps the total number of enables a multiple of the divider plus one, so the prescaler phase is always known. It then drives the final enable in the same cycle as the write. The zero-divider default is reached by a second reset followed by a full 32768-enable run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [1:0] {
        RG_COUNT   = 2'd0,
        RG_ALARM   = 2'd1,
        RG_STATUS  = 2'd2,
        RG_TRIMDIV = 2'd3
    } reg_sel_e;

    // event channel numbering inside the status register
    localparam int unsigned CH_ALARM = 0;
    localparam int unsigned CH_TICK  = 1;
    localparam int unsigned N_CH     = 2;
    localparam int unsigned EN_OFS   = 2;   // enable sits this far above its flag
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV_W   = 16,
    parameter int unsigned DEF_DIV = 32767
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] DEF_V = DEF_DIV[DIV_W-1:0];
    localparam logic [DIV_W-1:0] ONE   = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff_div;
    logic             hit;

    assign eff_div = (div_i == '0) ? DEF_V : div_i;
    assign hit     = (cnt_q >= eff_div);
    assign tick_o  = en_i & hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= hit ? '0 : cnt_q + ONE;
        end
    end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          cnt_we_i,
    input  logic          alm_we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] count_o,
    output logic [DW-1:0] alarm_o,
    output logic          match_o
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] count_q;
    logic [DW-1:0] alarm_q;
    logic [DW-1:0] next_sec;

    assign next_sec = count_q + ONE;
    assign match_o  = tick_i & ~cnt_we_i & (next_sec == alarm_q);
    assign count_o  = count_q;
    assign alarm_o  = alarm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_we_i) begin
            count_q <= wdata_i;       // software write wins over a tick
        end else if (tick_i) begin
            count_q <= next_sec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else if (alm_we_i) begin
            alarm_q <= wdata_i;
        end
    end
endmodule

// File: rtl/rtc_status.sv
module rtc_status
    import rtc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [N_CH+EN_OFS-1:0]  wdata_i,
    input  logic [N_CH-1:0]         set_i,
    output logic [N_CH-1:0]         flag_o,
    output logic [N_CH-1:0]         en_o
);
    logic [N_CH-1:0] flag_q;
    logic [N_CH-1:0] en_q;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
                en_q[g]   <= 1'b0;
            end else begin
                // a new event beats a simultaneous write-one-to-clear
                flag_q[g] <= set_i[g] | (flag_q[g] & ~(we_i & wdata_i[g]));
                if (we_i) begin
                    en_q[g] <= wdata_i[g+EN_OFS];
                end
            end
        end
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned DW      = 32,
    parameter int unsigned DIV_W   = 16,
    parameter int unsigned DEF_DIV = 32767
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en32k,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq_tick,
    output logic          irq_alarm
);
    localparam int unsigned ST_W = N_CH + EN_OFS;

    reg_sel_e        sel;
    logic            we_cnt, we_alm, we_st, we_td;
    logic            tick;
    logic            match;
    logic [DW-1:0]   sec_count;
    logic [DW-1:0]   alarm_val;
    logic [DW-1:0]   trimdiv_q;
    logic [N_CH-1:0] flags;
    logic [N_CH-1:0] enables;
    logic [N_CH-1:0] ev_set;

    assign sel    = reg_sel_e'(bus_addr);
    assign we_cnt = bus_we && (sel == RG_COUNT);
    assign we_alm = bus_we && (sel == RG_ALARM);
    assign we_st  = bus_we && (sel == RG_STATUS);
    assign we_td  = bus_we && (sel == RG_TRIMDIV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trimdiv_q <= '0;
        end else if (we_td) begin
            trimdiv_q <= bus_wdata[DW-1:0];
        end
    end

    rtc_prescaler #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) i_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en32k),
        .div_i  (trimdiv_q[DIV_W-1:0]),
        .tick_o (tick)
    );

    rtc_seconds #(.DW(DW)) i_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .cnt_we_i (we_cnt),
        .alm_we_i (we_alm),
        .wdata_i  (bus_wdata[DW-1:0]),
        .count_o  (sec_count),
        .alarm_o  (alarm_val),
        .match_o  (match)
    );

    always_comb begin
        ev_set           = '0;
        ev_set[CH_ALARM] = match;
        ev_set[CH_TICK]  = tick;
    end

    rtc_status i_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we_st),
        .wdata_i (bus_wdata[ST_W-1:0]),
        .set_i   (ev_set),
        .flag_o  (flags),
        .en_o    (enables)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            RG_COUNT:   bus_rdata = sec_count;
            RG_ALARM:   bus_rdata = alarm_val;
            RG_STATUS:  bus_rdata = {{(32-ST_W){1'b0}}, enables, flags};
            RG_TRIMDIV: bus_rdata = trimdiv_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_alarm = flags[CH_ALARM] & enables[CH_ALARM];
    assign irq_tick  = flags[CH_TICK]  & enables[CH_TICK];
endmodule

// File: rtl/rtc_core_sva.sv
module rtc_core_sva #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en32k,
    input logic          bus_we,
    input logic [1:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          tick,
    input logic [DW-1:0] sec_count,
    input logic [1:0]    flags,
    input logic          irq_alarm,
    input logic          irq_tick
);
    logic wr_cnt, wr_st;
    assign wr_cnt = bus_we && (bus_addr == 2'd0);
    assign wr_st  = bus_we && (bus_addr == 2'd2);

    a_r2_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en32k);

    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt) |=> (sec_count == $past(sec_count) + 1'b1));

    a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(sec_count));

    a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (sec_count == $past(bus_wdata[DW-1:0])));

    a_r6_tick_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flags[1]);

    a_r7_clear_tick_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && bus_wdata[1] && !tick) |=> !flags[1]);

    a_r9_alarm_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && !bus_wdata[2]) |=> !irq_alarm);

    a_r9_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && !bus_wdata[3]) |=> !irq_tick);
endmodule

bind rtc_core rtc_core_sva #(.DW(DW)) i_rtc_core_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .en32k     (en32k),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tick      (tick),
    .sec_count (sec_count),
    .flags     (flags),
    .irq_alarm (irq_alarm),
    .irq_tick  (irq_tick)
);

// File: tb/test_rtc_core.sv
`timescale 1ns/1ps
module test_rtc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en32k = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_tick, irq_alarm;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rtc_core i_rtc_core (
        .clk(clk), .rst_n(rst_n), .en32k(en32k),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_tick(irq_tick), .irq_alarm(irq_alarm)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en32k = 1'b0;
        bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // write in the same cycle as one enable pulse
    task automatic wr_with_en(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; en32k = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; en32k = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        en32k = 1'b1;
        repeat (n) @(negedge clk);
        en32k = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 irq_tick reset", {31'b0, irq_tick}, 32'h0);
        check("R1 irq_alarm reset", {31'b0, irq_alarm}, 32'h0);
    endtask

    task automatic t_divider();
        logic [31:0] v;
        wr(2'd3, 32'h0000_0003);
        pulse(3);
        rd(2'd0, v); check("R2 no tick before D+1 enables", v, 32'd0);
        repeat (20) @(negedge clk);
        rd(2'd0, v); check("R2 idle cycles do not advance", v, 32'd0);
        pulse(1);
        rd(2'd0, v); check("R2 tick at D+1 enables", v, 32'd1);
        pulse(8);
        rd(2'd0, v); check("R4 two more ticks", v, 32'd3);
    endtask

    task automatic t_load();
        logic [31:0] v;
        wr(2'd0, 32'd100);
        rd(2'd0, v); check("R4 count load", v, 32'd100);
        pulse(4);
        rd(2'd0, v); check("R4 increment after load", v, 32'd101);
    endtask

    task automatic t_alarm();
        logic [31:0] v;
        wr(2'd1, 32'd103);
        wr(2'd2, 32'h3);           // clear both flags, enables off
        rd(2'd2, v); check("R7 flags cleared", v, 32'h0);
        pulse(4);
        rd(2'd2, v); check("R6 tick flag only at 102", v, 32'h2);
        wr(2'd2, 32'h3);
        pulse(4);
        rd(2'd0, v); check("R4 count reaches alarm", v, 32'd103);
        rd(2'd2, v); check("R6 both flags at match, enables off", v, 32'h3);
        check("R9 irq_alarm low while disabled", {31'b0, irq_alarm}, 32'h0);
        check("R9 irq_tick low while disabled", {31'b0, irq_tick}, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(2'd2, 32'hC);
        rd(2'd2, v); check("R8 enables set, flags kept", v, 32'hF);
        check("R9 irq_alarm high", {31'b0, irq_alarm}, 32'h1);
        check("R9 irq_tick high", {31'b0, irq_tick}, 32'h1);
        wr(2'd2, 32'hD);
        rd(2'd2, v); check("R7 clear alarm flag only", v, 32'hE);
        check("R9 irq_alarm drops with flag", {31'b0, irq_alarm}, 32'h0);
        check("R9 irq_tick stays", {31'b0, irq_tick}, 32'h1);
        wr(2'd2, 32'h0);
        rd(2'd2, v); check("R8 enables off, flag kept", v, 32'h2);
        check("R9 irq_tick gated by enable", {31'b0, irq_tick}, 32'h0);
        wr(2'd2, 32'hFFFF_FFF2);
        rd(2'd2, v); check("R8 upper bits read zero", v, 32'h0);
        wr(2'd2, 32'h3);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        pulse(3);
        wr_with_en(2'd0, 32'd500);
        rd(2'd0, v); check("R5 write beats tick", v, 32'd500);
        rd(2'd2, v); check("R6 tick flag set in collision", v, 32'h2);
        pulse(3);
        wr_with_en(2'd2, 32'h2);
        rd(2'd2, v); check("R7 set wins over clear", v, 32'h2);
        rd(2'd0, v); check("R4 tick after collision", v, 32'd501);
    endtask

    task automatic t_trim();
        logic [31:0] v;
        wr(2'd3, 32'hABCD_0001);
        rd(2'd3, v); check("R10 trim/divider readback", v, 32'hABCD_0001);
        pulse(2);
        rd(2'd0, v); check("R10 trim ignored, tick every 2", v, 32'd502);
    endtask

    task automatic t_default();
        logic [31:0] v;
        do_reset();
        rd(2'd3, v); check("R3 divider field zero", v, 32'h0);
        pulse(32767);
        rd(2'd0, v); check("R3 no tick before 32768 enables", v, 32'd0);
        pulse(1);
        rd(2'd0, v); check("R3 default tick at 32768", v, 32'd1);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_divider();
        t_load();
        t_alarm();
        t_irq();
        t_collide();
        t_trim();
        t_default();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule